// File: doc/BRIEF.md
# Indirect Peripheral Port Bridge

This bridge couples a 32-bit host register interface to an 8-bit peripheral bus shared by two chip-select groups. The host reaches every peripheral register in two steps through one command/status word: it first issues an address-latch command carrying the register offset, then a data command that writes a byte or fetches one. Each command starts one timed bus cycle on the selected group. The cycle has a setup phase, a strobe phase and a hold phase. A pending flag in the same word stays set for the whole cycle.

The host polls the port word until the pending flag drops. After a read it takes the captured byte from the low eight bits. A second register collects level interrupt requests from the two groups into sticky status bits that drive one host interrupt line. A write of a fixed key value clears those bits.

Top module: `ppb_bridge`

## Requirements
- R1: After reset the port word reads 0, the interrupt status reads 0, `host_irq` is 0, both chip selects are high, `pbus_ale` is 0, and `pbus_rd_n` and `pbus_wr_n` are 1.
- R2: A host write to the port offset (0x200) while idle is accepted on that clock edge. Bit 25 of the port word reads 1 from the following cycle for exactly SETUP_CYC+STROBE_CYC+HOLD_CYC cycles, then reads 0.
- R3: A host write to the port offset while bit 25 is 1 is ignored. It does not extend the cycle, does not change the command fields, and causes no bus activity on its target group.
- R4: The port word layout is fixed: bit 25 pending, bit 23 direction (1 = write), bit 20 group, bit 16 register select (0 = address latch, 1 = data), bits 7:0 byte. Bits 23, 20 and 16 echo the last accepted command. All other bits read 0.
- R5: Bit 20 selects the group: 0 drives `pbus_cs_n[0]` low and 1 drives `pbus_cs_n[1]` low, for the whole cycle. At most one chip select is low at any time, and none is low while idle.
- R6: A command with bit 16 = 0 is an address-latch cycle whatever bit 23 holds. `pbus_ale` is high for STROBE_CYC cycles and the byte is driven on `pbus_d` for the whole cycle.
- R7: A command with bit 16 = 1 and bit 23 = 1 is a data write. `pbus_wr_n` is low for STROBE_CYC cycles and the byte is driven on `pbus_d` for the whole cycle.
- R8: A command with bit 16 = 1 and bit 23 = 0 is a data read. `pbus_rd_n` is low for STROBE_CYC cycles and the bridge does not drive `pbus_d`. The bus value in the last strobe cycle appears in bits 7:0 when bit 25 falls.
- R9: At most one of the three strobes is active in any cycle. Strobes are active only while a cycle is pending.
- R10: A high level on `irq_src[g]` sets sticky status bit g, read in bits 1:0 at offset 0x3C. `host_irq` is the OR of the status bits.
- R11: A write of 0x70000000 to offset 0x3C clears the status bits, except those whose source is high in that same cycle. A write of any other value to 0x3C leaves them unchanged.
- R12: Host writes to any offset other than 0x200 start no bus cycle and leave the port word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for host side and peripheral bus |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | ADDR_W | Byte offset of the host access |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| host_irq | output | 1 | Host interrupt, OR of the sticky status bits |
| irq_src | input | 2 | Level interrupt requests from the two groups |
| pbus_d | inout | 8 | Peripheral data bus, driven by the bridge in write-type cycles |
| pbus_ale | output | 1 | Address-latch strobe, active high |
| pbus_rd_n | output | 1 | Read strobe, active low |
| pbus_wr_n | output | 1 | Write strobe, active low |
| pbus_cs_n | output | 2 | Group chip selects, active low |

## Verification
The assertions assume that a peripheral drives `pbus_d` only while `pbus_rd_n` is low, and that `irq_src`, `host_addr`, `host_wr` and `host_wdata` are synchronous to `clk` and settle between edges. They also assume the three phase lengths are each at least one cycle. The stimulus changes every host input and interrupt source on the falling clock edge. Its peripheral model drives the bus only during the read strobe and returns bytes from its own register arrays. Only one deliberate overlap is used: a second port write issued in the cycle right after an accepted one, to check that it is ignored.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  localparam int NUM_GRP  = 2;
  localparam int DAT_W    = 8;
  localparam int WORD_W   = 32;
  // bit positions of the command/status word (software depends on them)
  localparam int POS_PEND = 25;
  localparam int POS_WR   = 23;
  localparam int POS_GRP  = 20;
  localparam int POS_SEL  = 16;
  localparam logic [WORD_W-1:0] IRQ_CLR_KEY = 32'h7000_0000;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  typedef struct packed {
    logic             wr;
    logic             grp;
    logic             sel;
    logic [DAT_W-1:0] dat;
  } cmd_t;
endpackage

// File: rtl/ppb_rst_sync.sv
module ppb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ppb_cmd_codec.sv
module ppb_cmd_codec
  import ppb_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  input  logic              busy,
  input  cmd_t              cmd_q,
  input  logic [DAT_W-1:0]  data_q,
  output cmd_t              cmd_dec,
  output logic [WORD_W-1:0] word_out
);
  logic unused_bits;
  assign unused_bits = ^{word_in[WORD_W-1:POS_WR+1], word_in[POS_WR-1:POS_GRP+1],
                         word_in[POS_GRP-1:POS_SEL+1], word_in[POS_SEL-1:DAT_W]};

  always_comb begin
    cmd_dec.wr  = word_in[POS_WR];
    cmd_dec.grp = word_in[POS_GRP];
    cmd_dec.sel = word_in[POS_SEL];
    cmd_dec.dat = word_in[DAT_W-1:0];
  end

  always_comb begin
    word_out              = '0;
    word_out[POS_PEND]    = busy;
    word_out[POS_WR]      = cmd_q.wr;
    word_out[POS_GRP]     = cmd_q.grp;
    word_out[POS_SEL]     = cmd_q.sel;
    word_out[DAT_W-1:0]   = data_q;
  end
endmodule

// File: rtl/ppb_seq.sv
module ppb_seq
  import ppb_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  cmd_t               cmd_in,
  input  logic [DAT_W-1:0]   pd_in,
  output logic               busy,
  output cmd_t               cmd_q,
  output logic [DAT_W-1:0]   data_q,
  output logic               ale,
  output logic               rd_n,
  output logic               wr_n,
  output logic [NUM_GRP-1:0] cs_n,
  output logic [DAT_W-1:0]   pd_out,
  output logic               pd_oe
);
  localparam int MAX_SH  = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAX_LEN = (MAX_SH > STROBE_CYC) ? MAX_SH : STROBE_CYC;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);

  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [DAT_W-1:0]   cap_q, data_d;
  logic               cmd_ld, data_ld, cap_ld;
  logic               rd_cyc;

  assign rd_cyc = cmd_q.sel & ~cmd_q.wr;
  assign busy   = (phase_q != PH_IDLE);

  // next-state
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cmd_ld  = 1'b0;
    data_ld = 1'b0;
    data_d  = data_q;
    cap_ld  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = '0;
          cmd_ld  = 1'b1;
          data_ld = 1'b1;
          data_d  = cmd_in.dat;
        end
      end
      PH_SETUP: begin
        if (cnt_q == SETUP_LAST) begin
          phase_d = PH_STROBE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PH_STROBE: begin
        if (cnt_q == STROBE_LAST) begin
          phase_d = PH_HOLD;
          cnt_d   = '0;
          cap_ld  = rd_cyc;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PH_HOLD: begin
        if (cnt_q == HOLD_LAST) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
          data_ld = rd_cyc;
          data_d  = cap_q;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
      cap_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (cmd_ld)  cmd_q  <= cmd_in;
      if (data_ld) data_q <= data_d;
      if (cap_ld)  cap_q  <= pd_in;
    end
  end

  // bus outputs
  assign ale    = (phase_q == PH_STROBE) & ~cmd_q.sel;
  assign wr_n   = ~((phase_q == PH_STROBE) & cmd_q.sel & cmd_q.wr);
  assign rd_n   = ~((phase_q == PH_STROBE) & rd_cyc);
  assign pd_oe  = busy & ~rd_cyc;
  assign pd_out = cmd_q.dat;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_cs
    assign cs_n[g] = ~(busy & (cmd_q.grp == 1'(g)));
  end

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ale, ~rd_n, ~wr_n}) <= 1);
  assert_strobe_in_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || !rd_n || !wr_n) |-> (busy && !(&cs_n)));
  assert_one_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_no_drive_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !pd_oe);
  assert_start_sets_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_busy_ignores_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(cmd_q));
endmodule

// File: rtl/ppb_irq.sv
module ppb_irq #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic               clr,
  output logic [NUM_SRC-1:0] stat,
  output logic               irq
);
  logic [NUM_SRC-1:0] stat_d;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_comb stat_d[g] = src[g] | (stat[g] & ~clr);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat[g] <= 1'b0;
      else        stat[g] <= stat_d[g];
    end

    assert_source_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
      src[g] |=> stat[g]);
  end

  assign irq = |stat;

  assert_key_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(|src)) |=> !irq);
endmodule

// File: rtl/ppb_bridge.sv
module ppb_bridge
  import ppb_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PORT_OFS   = 'h200,
  parameter int IRQ_OFS    = 'h03C,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_irq,
  input  logic [1:0]        irq_src,
  inout  wire  [7:0]        pbus_d,
  output logic              pbus_ale,
  output logic              pbus_rd_n,
  output logic              pbus_wr_n,
  output logic [1:0]        pbus_cs_n
);
  logic               rst_n;
  logic               hit_port, hit_irq;
  logic               start, irq_clr, busy;
  cmd_t               cmd_dec, cmd_q;
  logic [DAT_W-1:0]   data_q, pd_out, pd_in;
  logic               pd_oe;
  logic [WORD_W-1:0]  port_word;
  logic [NUM_GRP-1:0] irq_stat;

  ppb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n(rst_n)
  );

  assign hit_port = (host_addr == ADDR_W'(PORT_OFS));
  assign hit_irq  = (host_addr == ADDR_W'(IRQ_OFS));
  assign start    = host_wr & hit_port;
  assign irq_clr  = host_wr & hit_irq & (host_wdata == IRQ_CLR_KEY);

  ppb_cmd_codec u_codec (
    .word_in(host_wdata), .busy(busy), .cmd_q(cmd_q), .data_q(data_q),
    .cmd_dec(cmd_dec), .word_out(port_word)
  );

  ppb_seq #(
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_in(cmd_dec), .pd_in(pd_in),
    .busy(busy), .cmd_q(cmd_q), .data_q(data_q),
    .ale(pbus_ale), .rd_n(pbus_rd_n), .wr_n(pbus_wr_n), .cs_n(pbus_cs_n),
    .pd_out(pd_out), .pd_oe(pd_oe)
  );

  ppb_irq #(.NUM_SRC(NUM_GRP)) u_irq (
    .clk(clk), .rst_n(rst_n), .src(irq_src), .clr(irq_clr),
    .stat(irq_stat), .irq(host_irq)
  );

  assign pbus_d = pd_oe ? pd_out : 'z;
  assign pd_in  = pbus_d;

  always_comb begin
    host_rdata = '0;
    if (hit_port)     host_rdata = port_word;
    else if (hit_irq) host_rdata[NUM_GRP-1:0] = irq_stat;
  end

  assert_other_offset_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !hit_port && !busy) |=> !busy);
  assert_wrong_key_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && hit_irq && host_wdata != IRQ_CLR_KEY && host_irq) |=> host_irq);
endmodule

// File: tb/ppb_bridge_tb_top.sv
module ppb_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP_CYC = 1, STROBE_CYC = 3, HOLD_CYC = 1;
  localparam int CYC = SETUP_CYC + STROBE_CYC + HOLD_CYC;
  localparam logic [11:0] A_PORT = 12'h200, A_IRQ = 12'h03C, A_OTHER = 12'h100;

  logic        clk, arst_n, host_wr, host_irq;
  logic [11:0] host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic [1:0]  irq_src, pbus_cs_n;
  logic        pbus_ale, pbus_rd_n, pbus_wr_n;
  wire  [7:0]  pbus_d;

  int checks = 0, errors = 0;

  ppb_bridge #(.SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)) dut_i (
    .clk(clk), .arst_n(arst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
    .irq_src(irq_src), .pbus_d(pbus_d), .pbus_ale(pbus_ale), .pbus_rd_n(pbus_rd_n),
    .pbus_wr_n(pbus_wr_n), .pbus_cs_n(pbus_cs_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // peripheral model
  function automatic logic [7:0] pat(input int g, input int a);
    return 8'(a) ^ ((g != 0) ? 8'hA5 : 8'h3C);
  endfunction

  logic [7:0] pmem [2][256];
  logic [7:0] paddr [2];
  logic [7:0] exp_mem [2][256];
  logic [7:0] exp_addr [2];
  logic       gsel;
  logic [7:0] model_drv;

  assign gsel      = ~pbus_cs_n[1];
  assign model_drv = pmem[gsel][paddr[gsel]];
  assign pbus_d    = (!pbus_rd_n) ? model_drv : 8'hzz;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int g = 0; g < 2; g++) begin
        paddr[g] <= 8'h00;
        for (int a = 0; a < 256; a++) pmem[g][a] <= pat(g, a);
      end
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (!pbus_cs_n[g]) begin
          if (pbus_ale)   paddr[g] <= pbus_d;
          if (!pbus_wr_n) pmem[g][paddr[g]] <= pbus_d;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge, returns at the next one
  task automatic host_write(input logic [11:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] v);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  // scoreboard
  logic [7:0] sb_q[$];
  event       op_done;
  bit         last_rd;

  initial begin
    forever begin
      logic [31:0] w;
      logic [7:0]  e;
      @(op_done);
      if (last_rd) begin
        w = host_rdata;
        if (sb_q.size() == 0) chk(1'b0, "R8 scoreboard underflow", 0, 1);
        else begin
          e = sb_q.pop_front();
          chk(w[7:0] == e, "R8 read byte", {24'h0, w[7:0]}, {24'h0, e});
        end
      end
    end
  end

  task automatic port_op(input bit wr, input bit g, input bit sel, input logic [7:0] d);
    logic [31:0] word, v, exp_word;
    logic [7:0]  rexp;
    logic [1:0]  cs_exp;
    bit          rd, cs_ok, pd_ok;
    int          cnt, n_ale, n_rd, n_wr;
    rd     = sel && !wr;
    rexp   = exp_mem[g][exp_addr[g]];
    word   = (32'(wr) << 23) | (32'(g) << 20) | (32'(sel) << 16) | 32'(d);
    cs_exp = g ? 2'b01 : 2'b10;
    if (rd) sb_q.push_back(rexp);
    host_write(A_PORT, word);
    cnt = 0; n_ale = 0; n_rd = 0; n_wr = 0; cs_ok = 1; pd_ok = 1;
    forever begin
      rd_reg(A_PORT, v);
      if (!v[25] || cnt > 50) break;
      cnt++;
      if (pbus_cs_n != cs_exp) cs_ok = 0;
      if (pbus_ale) n_ale++;
      if (!pbus_rd_n) n_rd++;
      if (!pbus_wr_n) n_wr++;
      if (!rd && pbus_d !== d) pd_ok = 0;
      @(negedge clk);
    end
    chk(cnt == CYC, "R2 pending length", cnt, CYC);
    chk(cs_ok, "R5 chip select", {30'h0, pbus_cs_n}, {30'h0, cs_exp});
    chk(pbus_cs_n == 2'b11, "R5 idle selects", {30'h0, pbus_cs_n}, 3);
    if (!sel) begin
      chk(n_ale == STROBE_CYC && n_rd == 0 && n_wr == 0, "R6 latch strobes", n_ale, STROBE_CYC);
      chk(pd_ok, "R6 latch byte driven", 0, 1);
      exp_addr[g] = d;
      chk(paddr[g] == d, "R6 latched offset", {24'h0, paddr[g]}, {24'h0, d});
    end else if (wr) begin
      chk(n_wr == STROBE_CYC && n_rd == 0 && n_ale == 0, "R7 write strobes", n_wr, STROBE_CYC);
      chk(pd_ok, "R7 write byte driven", 0, 1);
      exp_mem[g][exp_addr[g]] = d;
      chk(pmem[g][exp_addr[g]] == d, "R7 peripheral byte",
          {24'h0, pmem[g][exp_addr[g]]}, {24'h0, d});
    end else begin
      chk(n_rd == STROBE_CYC && n_wr == 0 && n_ale == 0, "R8 read strobes", n_rd, STROBE_CYC);
    end
    last_rd = rd;
    -> op_done;
    exp_word = (32'(wr) << 23) | (32'(g) << 20) | (32'(sel) << 16) | 32'(rd ? rexp : d);
    chk(v == exp_word, "R4 port word", v, exp_word);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, a_word, b_word;
    int cnt;
    bit cs0_quiet;
    for (int g = 0; g < 2; g++) begin
      exp_addr[g] = 8'h00;
      for (int a = 0; a < 256; a++) exp_mem[g][a] = pat(g, a);
    end
    arst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0; irq_src = 2'b00;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_reg(A_PORT, v);
    chk(v == 0, "R1 port word", v, 0);
    rd_reg(A_IRQ, v);
    chk(v == 0, "R1 irq status", v, 0);
    chk(pbus_cs_n == 2'b11 && !pbus_ale && pbus_rd_n && pbus_wr_n && !host_irq,
        "R1 bus idle", {27'h0, pbus_cs_n, pbus_ale, pbus_rd_n, pbus_wr_n}, 32'h1b);
    @(negedge clk);

    // group 0 fifo register
    port_op(1, 0, 0, 8'h1E);
    port_op(1, 0, 1, 8'hC3);
    port_op(0, 0, 1, 8'h00);
    // group 1, both sub-channel fifos
    port_op(1, 1, 0, 8'h1F);
    port_op(1, 1, 1, 8'h5A);
    port_op(1, 1, 0, 8'h5F);
    port_op(1, 1, 1, 8'hA6);
    port_op(1, 1, 0, 8'h1F);
    port_op(0, 1, 1, 8'h00);
    port_op(1, 1, 0, 8'h5F);
    port_op(0, 1, 1, 8'h00);
    // R6 latch with direction bit clear, then read an untouched register
    port_op(0, 0, 0, 8'h40);
    port_op(0, 0, 1, 8'h00);
    port_op(0, 0, 0, 8'h1E);
    port_op(0, 0, 1, 8'h00);

    // R3 command during pending cycle is ignored
    port_op(1, 0, 0, 8'h40);
    a_word = (32'h1 << 23) | (32'h1 << 20) | (32'h1 << 16) | 32'h77;
    b_word = (32'h1 << 23) | (32'h1 << 16) | 32'h99;
    host_write(A_PORT, a_word);
    host_write(A_PORT, b_word);
    cnt = 1; cs0_quiet = 1;
    forever begin
      rd_reg(A_PORT, v);
      if (!v[25] || cnt > 50) break;
      cnt++;
      if (!pbus_cs_n[0]) cs0_quiet = 0;
      @(negedge clk);
    end
    chk(cnt == CYC, "R3 cycle not extended", cnt, CYC);
    chk(cs0_quiet, "R3 ignored group quiet", 0, 1);
    chk(v == a_word, "R3 fields of first command", v, a_word);
    exp_mem[1][exp_addr[1]] = 8'h77;
    chk(pmem[1][8'h5F] == 8'h77, "R3 first command wrote", {24'h0, pmem[1][8'h5F]}, 32'h77);
    chk(pmem[0][8'h40] == exp_mem[0][8'h40], "R3 second command dropped",
        {24'h0, pmem[0][8'h40]}, {24'h0, exp_mem[0][8'h40]});
    @(negedge clk);
    rd_reg(A_PORT, v);
    chk(!v[25], "R3 no queued cycle", v, a_word);

    // R12 other offset
    host_write(A_OTHER, (32'h1 << 23) | (32'h1 << 16) | 32'hAA);
    rd_reg(A_PORT, v);
    chk(v == a_word, "R12 port word unchanged", v, a_word);
    chk(pbus_cs_n == 2'b11, "R12 no bus cycle", {30'h0, pbus_cs_n}, 3);
    @(negedge clk);

    // R10 / R11 interrupt status
    irq_src = 2'b01;
    @(negedge clk);
    irq_src = 2'b00;
    rd_reg(A_IRQ, v);
    chk(v == 32'h1 && host_irq, "R10 status sets", v, 1);
    @(negedge clk);
    rd_reg(A_IRQ, v);
    chk(v == 32'h1, "R10 status sticky", v, 1);
    host_write(A_IRQ, 32'h1234_5678);
    rd_reg(A_IRQ, v);
    chk(v == 32'h1 && host_irq, "R11 wrong key ignored", v, 1);
    host_write(A_IRQ, 32'h7000_0000);
    rd_reg(A_IRQ, v);
    chk(v == 0 && !host_irq, "R11 key clears", v, 0);
    irq_src = 2'b10;
    @(negedge clk);
    host_write(A_IRQ, 32'h7000_0000);
    rd_reg(A_IRQ, v);
    chk(v == 32'h2 && host_irq, "R11 active source survives clear", v, 2);
    irq_src = 2'b00;
    @(negedge clk);
    host_write(A_IRQ, 32'h7000_0000);
    rd_reg(A_IRQ, v);
    chk(v == 0 && !host_irq, "R11 clear after source drops", v, 0);

    chk(sb_q.size() == 0, "R8 scoreboard drained", sb_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule